// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects level-sensitive interrupt requests from peripherals and routes each one, under software control, into one of three classes: fast, vectored or non-vectored. Fast-class requests drive a dedicated fast-interrupt output. Vectored and non-vectored requests share the normal-interrupt output.

For the normal interrupt, the block presents the handler address of the best vectored slot that is currently pending. There are sixteen ordered slots, and any request line can be bound to any slot at run time. When only unbound normal requests are pending, the block presents a programmable fallback address instead.

Software reads the vector register to claim an interrupt. Claiming blocks requests of the same or lower priority until software writes the vector register to close the service. Higher-priority slots can still interrupt a service in progress, so services nest.

A small synchronous register bus does configuration. Each cycle it performs one access: a write when `bus_wr_i` is high, otherwise a read. Read data is registered and appears one cycle after the access. All interrupt outputs are registered and follow their inputs with one cycle of latency.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `fiq_o`, `irq_o`, `vect_o` and `bus_rdata_o` are zero. All configuration (mask, class, fallback, slot controls, slot addresses) resets to zero.
- R2: `fiq_o` equals the OR of all requests whose enable bit (word 3) is 1 and whose class bit (word 4) is 1, where 1 means fast. It follows the inputs one cycle later.
- R3: A slot is active only when all of these hold: its enable bit (bit 5 of its control word at 0x20+n) is 1; the source selected by bits 4:0 is requesting; that source is enabled; and that source is in normal class.
- R4: `vect_o` carries the address (word 0x30+n) of the lowest-numbered active slot that is not blocked by the current service level.
- R5: A normal-class enabled request that is bound to no enabled slot is non-vectored. When no unblocked slot is active, `vect_o` shows the fallback address (word 5).
- R6: `irq_o` is 1 when an unblocked slot is active, or when a non-vectored request is pending while no service is open.
- R7: Reading word 6 returns the current vector. If `irq_o` would be asserted, the read opens a service at the winner's level, and every request of equal or lower priority is then blocked. A read with nothing pending opens no service.
- R8: While a service is open, a lower-numbered slot still raises `irq_o` and takes over `vect_o`.
- R9: Writing word 6 closes the most recently opened (highest-priority) service. When no service is open, the write has no effect.
- R10: Word 0 reads the raw requests, word 1 the enabled fast requests, word 2 the enabled normal requests. Words 3, 4, 5, 0x20+n and 0x30+n read back what was written. All other words read as zero.
- R11: Rewriting a slot's source field changes the arbitration result in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | NSRC | Level request lines |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Word address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Registered read data |
| fiq_o | output | 1 | Fast interrupt to the processor |
| irq_o | output | 1 | Normal interrupt to the processor |
| vect_o | output | DW | Handler address for the normal interrupt |

## Verification
The bench builds the block with its defaults: 32 request lines and 16 slots. With these values every bit of the 5-bit source field and every slot position can be reached, so the bench can bind a slot to any line and make any slot number win. A behavioural model keeps open services in a queue and predicts every output in every cycle. Directed sequences cover class changes, nested preemption, closing an empty service and claiming the fallback level. A long random phase then mixes request patterns with arbitrary register traffic.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned REG_RAW  = 0;
  localparam int unsigned REG_FAST = 1;
  localparam int unsigned REG_NORM = 2;
  localparam int unsigned REG_EN   = 3;
  localparam int unsigned REG_SEL  = 4;
  localparam int unsigned REG_DFLT = 5;
  localparam int unsigned REG_VECT = 6;

  typedef enum logic [1:0] {
    RGN_BASE = 2'b00,
    RGN_RSV  = 2'b01,
    RGN_CTL  = 2'b10,
    RGN_ADR  = 2'b11
  } region_e;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned SW    = $clog2(NSRC),
  parameter int unsigned IW    = $clog2(NSLOT),
  parameter int unsigned AW    = IW + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  input  logic [IW-1:0]              lk_idx,
  output logic [NSRC-1:0]            src_en,
  output logic [NSRC-1:0]            src_fast,
  output logic [DW-1:0]              dflt_addr,
  output logic [NSLOT-1:0]           slot_en,
  output logic [NSLOT-1:0][SW-1:0]   slot_src,
  output logic [DW-1:0]              lk_addr,
  output logic [DW-1:0]              cfg_rdata
);
  region_e         rgn;
  logic [IW-1:0]   idx;
  logic [DW-1:0]   adr_mem [NSLOT];

  assign rgn = region_e'(addr[AW-1:AW-2]);
  assign idx = addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_en    <= '0;
      src_fast  <= '0;
      dflt_addr <= '0;
      slot_en   <= '0;
      slot_src  <= '0;
      for (int i = 0; i < NSLOT; i++) adr_mem[i] <= '0;
    end else if (wr_en) begin
      case (rgn)
        RGN_BASE: begin
          if (idx == IW'(REG_EN))   src_en    <= wdata[NSRC-1:0];
          if (idx == IW'(REG_SEL))  src_fast  <= wdata[NSRC-1:0];
          if (idx == IW'(REG_DFLT)) dflt_addr <= wdata;
        end
        RGN_CTL: begin
          slot_en[idx]  <= wdata[SW];
          slot_src[idx] <= wdata[SW-1:0];
        end
        RGN_ADR: adr_mem[idx] <= wdata;
        default: ;
      endcase
    end
  end

  assign lk_addr = adr_mem[lk_idx];

  always_comb begin
    cfg_rdata = '0;
    case (rgn)
      RGN_BASE: begin
        if (idx == IW'(REG_EN))   cfg_rdata = DW'(src_en);
        if (idx == IW'(REG_SEL))  cfg_rdata = DW'(src_fast);
        if (idx == IW'(REG_DFLT)) cfg_rdata = dflt_addr;
      end
      RGN_CTL: cfg_rdata = DW'({slot_en[idx], slot_src[idx]});
      RGN_ADR: cfg_rdata = adr_mem[idx];
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned SW    = $clog2(NSRC),
  parameter int unsigned IW    = $clog2(NSLOT),
  parameter int unsigned LW    = $clog2(NSLOT + 2)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NSRC-1:0]           req_norm,
  input  logic [NSLOT-1:0]          slot_en,
  input  logic [NSLOT-1:0][SW-1:0]  slot_src,
  input  logic [LW-1:0]             lvl_lim,
  output logic                      hit,
  output logic [IW-1:0]             win,
  output logic                      nv_pend
);
  logic [NSLOT-1:0] act;
  logic [NSLOT-1:0] elig;
  logic [NSRC-1:0]  bound;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign act[g]  = slot_en[g] & req_norm[slot_src[g]];
    assign elig[g] = act[g] & (LW'(g) < lvl_lim);
  end

  always_comb begin
    bound = '0;
    for (int i = 0; i < NSLOT; i++)
      if (slot_en[i]) bound[slot_src[i]] = 1'b1;
  end

  assign nv_pend = |(req_norm & ~bound);

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (elig[i]) begin
        hit = 1'b1;
        win = IW'(i);
      end
  end

  // R4
  win_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (elig[win] && ((elig & ((NSLOT'(1) << win) - NSLOT'(1))) == '0)));
  // R4
  no_win_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (elig == '0));
endmodule

// File: rtl/vic_svc.sv
module vic_svc #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned LW    = $clog2(NSLOT + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic [LW-1:0] cur_lvl
);
  localparam int unsigned NLVL = NSLOT + 1;
  logic [NLVL-1:0] open_q;

  always_ff @(posedge clk) begin
    if (rst)       open_q <= '0;
    else if (push) open_q[push_lvl] <= 1'b1;
    else if (pop)  open_q <= open_q & (open_q - NLVL'(1));
  end

  always_comb begin
    cur_lvl = LW'(NLVL);
    for (int i = NLVL - 1; i >= 0; i--)
      if (open_q[i]) cur_lvl = LW'(i);
  end

  // R7
  push_above_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (push_lvl < cur_lvl));
  // R9
  empty_close_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && open_q == '0) |=> (open_q == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned SW    = $clog2(NSRC),
  parameter int unsigned IW    = $clog2(NSLOT),
  parameter int unsigned AW    = IW + 2,
  parameter int unsigned LW    = $clog2(NSLOT + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_req_i,
  input  logic            bus_sel_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            fiq_o,
  output logic            irq_o,
  output logic [DW-1:0]   vect_o
);
  logic [NSRC-1:0]          src_en, src_fast, fast_req, norm_req;
  logic [DW-1:0]            dflt_addr, lk_addr, cfg_rdata, rd_mux, vect_nxt;
  logic [NSLOT-1:0]         slot_en;
  logic [NSLOT-1:0][SW-1:0] slot_src;
  logic [IW-1:0]            win;
  logic [LW-1:0]            cur_lvl, push_lvl;
  logic                     hit, nv_pend, dflt_ok, irq_nxt;
  logic                     base_rgn, wr_acc, rd_acc, rd_vect, wr_vect;
  logic [IW-1:0]            idx;

  assign wr_acc   = bus_sel_i & bus_wr_i;
  assign rd_acc   = bus_sel_i & ~bus_wr_i;
  assign base_rgn = (region_e'(bus_addr_i[AW-1:AW-2]) == RGN_BASE);
  assign idx      = bus_addr_i[IW-1:0];
  assign rd_vect  = rd_acc & base_rgn & (idx == IW'(REG_VECT));
  assign wr_vect  = wr_acc & base_rgn & (idx == IW'(REG_VECT));

  vic_regs #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW), .SW(SW), .IW(IW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_acc), .addr(bus_addr_i), .wdata(bus_wdata_i),
    .lk_idx(win), .src_en(src_en), .src_fast(src_fast), .dflt_addr(dflt_addr),
    .slot_en(slot_en), .slot_src(slot_src), .lk_addr(lk_addr), .cfg_rdata(cfg_rdata)
  );

  assign fast_req = irq_req_i & src_en & src_fast;
  assign norm_req = irq_req_i & src_en & ~src_fast;

  vic_arb #(.NSRC(NSRC), .NSLOT(NSLOT), .SW(SW), .IW(IW), .LW(LW)) u_arb (
    .clk(clk), .rst(rst), .req_norm(norm_req), .slot_en(slot_en), .slot_src(slot_src),
    .lvl_lim(cur_lvl), .hit(hit), .win(win), .nv_pend(nv_pend)
  );

  assign dflt_ok  = (cur_lvl == LW'(NSLOT + 1));
  assign irq_nxt  = hit | (nv_pend & dflt_ok);
  assign vect_nxt = hit ? lk_addr : dflt_addr;
  assign push_lvl = hit ? LW'(win) : LW'(NSLOT);

  vic_svc #(.NSLOT(NSLOT), .LW(LW)) u_svc (
    .clk(clk), .rst(rst), .push(rd_vect & irq_nxt), .push_lvl(push_lvl),
    .pop(wr_vect), .cur_lvl(cur_lvl)
  );

  always_comb begin
    rd_mux = cfg_rdata;
    if (base_rgn) begin
      if (idx == IW'(REG_RAW))  rd_mux = DW'(irq_req_i);
      if (idx == IW'(REG_FAST)) rd_mux = DW'(fast_req);
      if (idx == IW'(REG_NORM)) rd_mux = DW'(norm_req);
      if (idx == IW'(REG_VECT)) rd_mux = vect_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_o       <= 1'b0;
      irq_o       <= 1'b0;
      vect_o      <= '0;
      bus_rdata_o <= '0;
    end else begin
      fiq_o  <= |fast_req;
      irq_o  <= irq_nxt;
      vect_o <= vect_nxt;
      if (rd_acc) bus_rdata_o <= rd_mux;
    end
  end

  // R2
  fast_out_chk: assert property (@(posedge clk) disable iff (rst)
    (|fast_req) |=> fiq_o);
  // R7
  idle_claim_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_vect && !irq_nxt) |=> $stable(cur_lvl));
  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit && !nv_pend) |=> !irq_o);
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_req = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, vect;
  logic        fiq, irq;

  int nchk = 0, nfail = 0;
  bit seen = 0, done = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst(rst), .irq_req_i(irq_req), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .fiq_o(fiq), .irq_o(irq), .vect_o(vect)
  );

  // behavioural model
  bit [31:0] m_en, m_sel, m_dflt;
  bit        m_sen [16];
  bit [4:0]  m_src [16];
  bit [31:0] m_adr [16];
  int        stk [$];
  bit        e_fiq, e_irq;
  bit [31:0] e_vect, e_rdata;
  bit [31:0] fr, nr, cov, vn;
  int        lim, best, a;
  bit        nvp, irqn;

  always @(posedge clk) begin
    seen = 1;
    if (rst) begin
      m_en = 0; m_sel = 0; m_dflt = 0;
      for (int s = 0; s < 16; s++) begin m_sen[s] = 0; m_src[s] = 0; m_adr[s] = 0; end
      stk.delete();
      e_fiq = 0; e_irq = 0; e_vect = 0; e_rdata = 0;
    end else begin
      fr  = irq_req & m_en & m_sel;
      nr  = irq_req & m_en & ~m_sel;
      lim = (stk.size() > 0) ? stk[0] : 17;
      best = -1; cov = 0;
      for (int s = 0; s < 16; s++)
        if (m_sen[s]) begin
          cov[m_src[s]] = 1'b1;
          if (best < 0 && nr[m_src[s]] && s < lim) best = s;
        end
      nvp  = |(nr & ~cov);
      irqn = (best >= 0) || (nvp && lim == 17);
      vn   = (best >= 0) ? m_adr[best] : m_dflt;
      e_fiq = |fr; e_irq = irqn; e_vect = vn;
      a = int'(bus_addr);
      if (bus_sel && !bus_wr) begin
        if (a == 0) e_rdata = irq_req;
        else if (a == 1) e_rdata = fr;
        else if (a == 2) e_rdata = nr;
        else if (a == 3) e_rdata = m_en;
        else if (a == 4) e_rdata = m_sel;
        else if (a == 5) e_rdata = m_dflt;
        else if (a == 6) e_rdata = vn;
        else if (a >= 32 && a < 48) e_rdata = {26'd0, m_sen[a-32], m_src[a-32]};
        else if (a >= 48) e_rdata = m_adr[a-48];
        else e_rdata = 0;
        if (a == 6 && irqn) stk.push_front((best >= 0) ? best : 16);
      end
      if (bus_sel && bus_wr) begin
        if (a == 3) m_en = bus_wdata;
        else if (a == 4) m_sel = bus_wdata;
        else if (a == 5) m_dflt = bus_wdata;
        else if (a == 6) begin if (stk.size() > 0) void'(stk.pop_front()); end
        else if (a >= 32 && a < 48) begin m_sen[a-32] = bus_wdata[5]; m_src[a-32] = bus_wdata[4:0]; end
        else if (a >= 48) m_adr[a-48] = bus_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (seen && !done) begin
      chk("R2 model fiq", {31'd0, fiq}, {31'd0, e_fiq});
      chk("R6 model irq", {31'd0, irq}, {31'd0, e_irq});
      chk("R4 model vect", vect, e_vect);
      chk("R10 model rdata", bus_rdata, e_rdata);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int ad, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = 6'(ad); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int ad);
    bus_sel = 1; bus_wr = 0; bus_addr = 6'(ad);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk("R1 fiq", {31'd0, fiq}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 vect", vect, 0);
    chk("R1 rdata", bus_rdata, 0);
    rst = 0;
    step();
    chk("R1 after", {31'd0, irq}, 0);

    wr(3, 32'hFFFF_FFFF);
    wr(4, 32'h0000_1000);
    wr(5, 32'hD000_0000);
    for (int s = 0; s < 16; s++) wr(48 + s, 32'hA000_0000 + s * 16);
    wr(32, 32'h25);
    wr(35, 32'h29);
    wr(39, 32'h22);
    rd(4);
    chk("R10 sel readback", bus_rdata, 32'h0000_1000);

    irq_req = 32'h0000_1000; step();
    chk("R2 fast", {31'd0, fiq}, 1);
    chk("R2 no normal", {31'd0, irq}, 0);

    irq_req = 32'h0000_0200; step();
    chk("R4 single slot", vect, 32'hA000_0030);
    chk("R6 irq", {31'd0, irq}, 1);
    irq_req = 32'h0000_0204; step();
    chk("R4 lower slot wins", vect, 32'hA000_0030);
    irq_req = 32'h0010_0000; step();
    chk("R5 fallback", vect, 32'hD000_0000);
    chk("R6 nonvectored irq", {31'd0, irq}, 1);
    irq_req = 32'h0010_0020; step();
    chk("R4 slot0", vect, 32'hA000_0000);

    irq_req = 0;
    wr(32, 32'h05);
    irq_req = 32'h0000_0020; step();
    chk("R3 slot disabled", vect, 32'hD000_0000);
    wr(32, 32'h25);
    wr(4, 32'h0000_1200);
    irq_req = 32'h0000_0200; step();
    chk("R3 fast class not vectored", {31'd0, irq}, 0);
    chk("R3 fast class fiq", {31'd0, fiq}, 1);
    wr(4, 32'h0000_1000);

    irq_req = 32'h0000_0004; step();
    chk("R4 slot7", vect, 32'hA000_0070);
    rd(6);
    chk("R7 claim data", bus_rdata, 32'hA000_0070);
    step();
    chk("R7 held off", {31'd0, irq}, 0);
    irq_req = 32'h0000_0204; step();
    chk("R8 preempt irq", {31'd0, irq}, 1);
    chk("R8 preempt vect", vect, 32'hA000_0030);
    rd(6);
    chk("R7 nested claim", bus_rdata, 32'hA000_0030);
    step();
    chk("R7 nested held", {31'd0, irq}, 0);
    wr(6, 0); step();
    chk("R9 close inner", {31'd0, irq}, 1);
    wr(6, 0);
    wr(6, 0);
    irq_req = 32'h0010_0000; step();
    chk("R9 empty close", {31'd0, irq}, 1);
    rd(6);
    chk("R7 fallback claim", bus_rdata, 32'hD000_0000);
    step();
    chk("R7 fallback held", {31'd0, irq}, 0);
    irq_req = 32'h0010_0200; step();
    chk("R8 over fallback", {31'd0, irq}, 1);
    wr(6, 0);

    irq_req = 0;
    wr(32, 32'h22);
    irq_req = 32'h0000_0004; step();
    chk("R11 rebind", vect, 32'hA000_0000);

    irq_req = 32'h0000_1080;
    rd(0); chk("R10 raw", bus_rdata, 32'h0000_1080);
    rd(1); chk("R10 fast status", bus_rdata, 32'h0000_1000);
    rd(2); chk("R10 normal status", bus_rdata, 32'h0000_0080);
    rd(35); chk("R10 slot ctl", bus_rdata, 32'h0000_0029);
    rd(10); chk("R10 unused word", bus_rdata, 0);

    for (int c = 0; c < 4000; c++) begin
      irq_req = $urandom & $urandom & $urandom;
      if (($urandom % 4) == 0) begin
        bus_sel = 1;
        bus_wr = $urandom % 2;
        bus_addr = 6'($urandom);
        bus_wdata = (($urandom % 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      end else begin
        bus_sel = 0; bus_wr = 0;
      end
      step();
    end
    bus_sel = 0; bus_wr = 0;
    step();
    finish_run();
  end
endmodule